// File: doc/BRIEF.md
# External Interrupt Sense and Status

This block watches a bank of external interrupt pins and turns each one into an active-high, level-style request for a parent interrupt controller. Each pin arrives asynchronously. It passes through a synchroniser, and then a detector that software configures per pin. The detector can track a low level, or it can catch a falling edge, a rising edge or either edge.

Detected events are held in a per-pin status bit, and that bit drives the pin's request output. In an edge mode, software acknowledges an event by writing a zero to the status bit. In low-level mode the status bit simply mirrors the inverted pin, so a clear write does nothing there.

Software reaches the block through a small register port. A valid, write, address and data bundle carries each access. Read data is registered and appears after the clock edge of the read cycle.

Top module: `extint_sense_bank`

## Requirements
- R1: While reset is asserted, every status bit, every sense field, every request output and the read data are zero.
- R2: The mode register at offset 0x14 holds a 2-bit field for pin n at bits [2n+1:2n]. Writes to it read back unchanged, and bits above the last field read as zero.
- R3: Mode value 1 (falling) sets the pin's status bit on a high-to-low change only; a rising change leaves it untouched.
- R4: Mode value 2 (rising) sets the status bit on a low-to-high change only.
- R5: Mode value 3 (both) sets the status bit on either change of the pin.
- R6: Mode value 0 (low level) makes the status bit equal to the inverse of the synchronised pin on every cycle.
- R7: The status register at offset 0x10 shows pin n at bit n. Writing 0 to bit n clears it when the pin's mode is nonzero.
- R8: In low-level mode, writing 0 to the status bit has no effect.
- R9: Writing 1 to a status bit leaves that bit unchanged, whether it is set or clear.
- R10: When an edge event and a clearing write land on the same clock edge, the status bit ends set.
- R11: Request output n is high exactly while status bit n is set.
- R12: Read data is zero outside a read, and a read of any offset other than 0x10 and 0x14 returns zero. Read data is valid after the clock edge that samples the read.
- R13: A pin change reaches the status bit on the third rising clock edge after it, never on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_req | output | NUM_PINS | Active-high requests to the parent controller |

## Verification
The hardest case to reach from the ports is the collision between a newly detected edge and a clearing write to the same status bit on the same clock edge. An edge only reaches the status logic three edges after the pin moves. To force the collision, the bench changes the pin on a falling clock edge, waits exactly two more falling edges, and only then presents the clearing write, so that both act on the third rising edge. The latency check on the same path pins down that rising edge, which confirms the collision is genuine.

// File: rtl/extint_pkg.sv
package extint_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_RISE = 2'd2,
      SENSE_BOTH = 2'd3
   } sense_e;

   // Decide whether the observed transition is an event for the given mode.
   function automatic logic edge_hit(sense_e mode, logic rise, logic fall);
      logic hit;
      case (mode)
         SENSE_FALL: hit = fall;
         SENSE_RISE: hit = rise;
         SENSE_BOTH: hit = rise | fall;
         default:    hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("extint_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[k] <= '0;
            else        chain_q[k] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[k] <= '0;
            else        chain_q[k] <= chain_q[k-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/extint_chan.sv
module extint_chan
   import extint_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sync_in,
   input  sense_e mode,
   input  logic   clr_req,
   output logic   prev_q,
   output logic   status_q
);

   logic rise;
   logic fall;
   logic hit;

   assign rise = sync_in & ~prev_q;
   assign fall = ~sync_in & prev_q;
   assign hit  = edge_hit(mode, rise, fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= 1'b0;
         status_q <= 1'b0;
      end else begin
         prev_q <= sync_in;
         if (mode == SENSE_LOW)
            status_q <= ~sync_in;      // level mode: follow the pin, ignore clears
         else if (hit)
            status_q <= 1'b1;          // event beats a simultaneous clear
         else if (clr_req)
            status_q <= 1'b0;
      end
   end

endmodule

// File: rtl/extint_regs.sv
module extint_regs #(
   parameter int              NUM_PINS   = 8,
   parameter int              ADDR_W     = 8,
   parameter int              DATA_W     = 32,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h10,
   parameter logic [ADDR_W-1:0] SENSE_OFS  = 'h14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_valid,
   input  logic                  reg_write,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   input  logic [NUM_PINS-1:0]   status_vec,
   output logic [2*NUM_PINS-1:0] sense_q,
   output logic [NUM_PINS-1:0]   clr_vec,
   output logic [DATA_W-1:0]     reg_rdata
);

   localparam int SENSE_W = 2 * NUM_PINS;

   if (SENSE_W > DATA_W) begin : g_bad_width
      $error("extint_regs: mode fields do not fit the data width");
   end
   if (STATUS_OFS == SENSE_OFS) begin : g_bad_map
      $error("extint_regs: register offsets collide");
   end

   logic wr_sense;
   logic wr_status;
   logic rd_en;
   logic [DATA_W-1:0] rd_next;

   assign wr_sense  = reg_valid & reg_write & (reg_addr == SENSE_OFS);
   assign wr_status = reg_valid & reg_write & (reg_addr == STATUS_OFS);
   assign rd_en     = reg_valid & ~reg_write;

   // Zero written to a status bit requests a clear; ones are ignored.
   assign clr_vec = {NUM_PINS{wr_status}} & ~reg_wdata[NUM_PINS-1:0];

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sense_q[2*n +: 2] <= 2'd0;
         else if (wr_sense) sense_q[2*n +: 2] <= reg_wdata[2*n +: 2];
      end
   end

   always_comb begin
      rd_next = '0;
      if (rd_en) begin
         if (reg_addr == SENSE_OFS)       rd_next[SENSE_W-1:0]  = sense_q;
         else if (reg_addr == STATUS_OFS) rd_next[NUM_PINS-1:0] = status_vec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_rdata <= '0;
      else        reg_rdata <= rd_next;
   end

endmodule

// File: rtl/extint_sense_bank.sv
module extint_sense_bank
   import extint_pkg::*;
#(
   parameter int              NUM_PINS    = 8,
   parameter int              ADDR_W      = 8,
   parameter int              DATA_W      = 32,
   parameter int              SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] STATUS_OFS  = 'h10,
   parameter logic [ADDR_W-1:0] SENSE_OFS   = 'h14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                reg_valid,
   input  logic                reg_write,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic [NUM_PINS-1:0] irq_req
);

   localparam int SENSE_W = 2 * NUM_PINS;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("extint_sense_bank: NUM_PINS must be positive");
   end

   logic [NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] status_q;
   logic [NUM_PINS-1:0] clr_vec;
   logic [SENSE_W-1:0]  sense_q;

   extint_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (sync_q)
   );

   extint_regs #(
      .NUM_PINS   (NUM_PINS),
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .STATUS_OFS (STATUS_OFS),
      .SENSE_OFS  (SENSE_OFS)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_valid  (reg_valid),
      .reg_write  (reg_write),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .status_vec (status_q),
      .sense_q    (sense_q),
      .clr_vec    (clr_vec),
      .reg_rdata  (reg_rdata)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_chan
      extint_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_in  (sync_q[n]),
         .mode     (sense_e'(sense_q[2*n +: 2])),
         .clr_req  (clr_vec[n]),
         .prev_q   (prev_q[n]),
         .status_q (status_q[n])
      );
   end

   assign irq_req = status_q;

endmodule

// File: rtl/extint_sense_bank_chk.sv
module extint_sense_bank_chk #(
   parameter int              NUM_PINS   = 8,
   parameter int              ADDR_W     = 8,
   parameter int              DATA_W     = 32,
   parameter logic [ADDR_W-1:0] STATUS_OFS = 'h10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_valid,
   input logic                  reg_write,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [DATA_W-1:0]     reg_wdata,
   input logic [DATA_W-1:0]     reg_rdata,
   input logic [NUM_PINS-1:0]   irq_req,
   input logic [2*NUM_PINS-1:0] sense_q,
   input logic [NUM_PINS-1:0]   sync_q,
   input logic [NUM_PINS-1:0]   prev_q
);

   // R12: no read in the previous cycle means idle read data.
   p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_valid && !reg_write) |-> reg_rdata == '0);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      // R6: level mode tracks the inverted synchronised pin.
      p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $past(sense_q[2*i +: 2]) == 2'd0
         |-> irq_req[i] == !$past(sync_q[i]));

      // R7: in an edge mode a request drops only after a clearing write.
      p_clear_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $fell(irq_req[i]) && $past(sense_q[2*i +: 2]) != 2'd0
         |-> $past(reg_valid && reg_write && reg_addr == STATUS_OFS && !reg_wdata[i]));

      // R13: in an edge mode a request rises only after a seen transition.
      p_rise_needs_edge_r13: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && $rose(irq_req[i]) && $past(sense_q[2*i +: 2]) != 2'd0
         |-> $past(sync_q[i] != prev_q[i]));
   end

endmodule

bind extint_sense_bank extint_sense_bank_chk #(
   .NUM_PINS   (NUM_PINS),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .STATUS_OFS (STATUS_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_valid (reg_valid),
   .reg_write (reg_write),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq_req   (irq_req),
   .sense_q   (sense_q),
   .sync_q    (sync_q),
   .prev_q    (prev_q)
);

// File: tb/extint_sense_bank_bench.sv
module extint_sense_bank_bench;

   localparam logic [7:0] A_STATUS = 8'h10;
   localparam logic [7:0] A_SENSE  = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin_in = 8'hFF;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic [7:0]  irq_req;

   int checks = 0;
   int bad = 0;
   logic [31:0] sense_sh = 32'h0;

   always #5 clk = ~clk;

   extint_sense_bank u_extint_sense_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .reg_valid (reg_valid),
      .reg_write (reg_write),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_req   (irq_req)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
      reg_valid = 1'b0;
   endtask

   task automatic set_mode(input int pin, input logic [1:0] m);
      sense_sh[2*pin +: 2] = m;
      wr(A_SENSE, sense_sh);
   endtask

   // Drive a pin on a falling edge; the result is sampled after the third rising edge.
   task automatic drive_pin(input int pin, input logic v);
      @(negedge clk);
      pin_in[pin] = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_pin(input int pin);
      wr(A_STATUS, ~(32'h1 << pin));
   endtask

   task automatic t_reset;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      chk(irq_req == 8'h00, "R1 reset irq", {24'h0, irq_req}, 32'h0);
      chk(reg_rdata == 32'h0, "R1 reset rdata", reg_rdata, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      rd(A_SENSE, d);
      chk(d == 32'h0, "R1 sense after reset", d, 32'h0);
      rd(A_STATUS, d);
      chk(d == 32'h0, "R1 status settles low with pins high", d, 32'h0);
   endtask

   task automatic t_sense_rw;
      logic [31:0] d;
      wr(A_SENSE, 32'hFFFF_FFFF);
      rd(A_SENSE, d);
      chk(d == 32'h0000_FFFF, "R2 upper bits read zero", d, 32'h0000_FFFF);
      wr(A_SENSE, 32'h1B1B_E4E4);
      rd(A_SENSE, d);
      chk(d == 32'h0000_E4E4, "R2 field readback", d, 32'h0000_E4E4);
      sense_sh = 32'h0;
      wr(A_SENSE, sense_sh);
      repeat (4) @(negedge clk);
      chk(irq_req == 8'h00, "R2 modes restored quiet", {24'h0, irq_req}, 32'h0);
   endtask

   task automatic t_level;
      logic [31:0] d;
      @(negedge clk);
      pin_in[2] = 1'b0;
      repeat (2) @(negedge clk);
      chk(irq_req[2] == 1'b0, "R13 level not yet after two edges", {31'h0, irq_req[2]}, 32'h0);
      @(negedge clk);
      chk(irq_req[2] == 1'b1, "R6 low level asserts", {31'h0, irq_req[2]}, 32'h1);
      rd(A_STATUS, d);
      chk(d == 32'h0000_0004, "R7 status bit position", d, 32'h4);
      clear_pin(2);
      chk(irq_req[2] == 1'b1, "R8 clear ignored in level mode", {31'h0, irq_req[2]}, 32'h1);
      rd(A_STATUS, d);
      chk(d[2] == 1'b1, "R8 status still set", d, 32'h4);
      drive_pin(2, 1'b1);
      chk(irq_req[2] == 1'b0, "R6 high level deasserts", {31'h0, irq_req[2]}, 32'h0);
   endtask

   task automatic t_fall;
      set_mode(0, 2'd1);
      @(negedge clk);
      pin_in[0] = 1'b0;
      repeat (2) @(negedge clk);
      chk(irq_req[0] == 1'b0, "R13 edge not yet after two edges", {31'h0, irq_req[0]}, 32'h0);
      @(negedge clk);
      chk(irq_req[0] == 1'b1, "R3 falling edge sets", {31'h0, irq_req[0]}, 32'h1);
      chk(irq_req == 8'h01, "R11 only pin 0 requests", {24'h0, irq_req}, 32'h1);
      clear_pin(0);
      chk(irq_req[0] == 1'b0, "R7 clear in edge mode", {31'h0, irq_req[0]}, 32'h0);
      drive_pin(0, 1'b1);
      @(negedge clk);
      chk(irq_req[0] == 1'b0, "R3 rising ignored in falling mode", {31'h0, irq_req[0]}, 32'h0);
   endtask

   task automatic t_rise;
      set_mode(1, 2'd2);
      drive_pin(1, 1'b0);
      @(negedge clk);
      chk(irq_req[1] == 1'b0, "R4 falling ignored in rising mode", {31'h0, irq_req[1]}, 32'h0);
      drive_pin(1, 1'b1);
      chk(irq_req[1] == 1'b1, "R4 rising edge sets", {31'h0, irq_req[1]}, 32'h1);
      repeat (3) @(negedge clk);
      chk(irq_req[1] == 1'b1, "R4 status holds after edge", {31'h0, irq_req[1]}, 32'h1);
      clear_pin(1);
      chk(irq_req[1] == 1'b0, "R7 rising clear", {31'h0, irq_req[1]}, 32'h0);
   endtask

   task automatic t_both;
      set_mode(3, 2'd3);
      drive_pin(3, 1'b0);
      chk(irq_req[3] == 1'b1, "R5 falling sets in both mode", {31'h0, irq_req[3]}, 32'h1);
      clear_pin(3);
      chk(irq_req[3] == 1'b0, "R5 cleared", {31'h0, irq_req[3]}, 32'h0);
      drive_pin(3, 1'b1);
      chk(irq_req[3] == 1'b1, "R5 rising sets in both mode", {31'h0, irq_req[3]}, 32'h1);
      clear_pin(3);
   endtask

   task automatic t_write_one;
      logic [31:0] d;
      set_mode(4, 2'd2);
      drive_pin(4, 1'b0);
      drive_pin(4, 1'b1);
      chk(irq_req == 8'h10, "R11 pin 4 requests alone", {24'h0, irq_req}, 32'h10);
      wr(A_STATUS, 32'hFFFF_FFFF);
      chk(irq_req == 8'h10, "R9 ones leave status unchanged", {24'h0, irq_req}, 32'h10);
      rd(A_STATUS, d);
      chk(d == 32'h10, "R9 status readback", d, 32'h10);
      clear_pin(4);
   endtask

   task automatic t_collide;
      set_mode(5, 2'd2);
      drive_pin(5, 1'b0);
      @(negedge clk);
      pin_in[5] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = A_STATUS; reg_wdata = ~(32'h1 << 5);
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0;
      chk(irq_req[5] == 1'b1, "R10 event wins over clear", {31'h0, irq_req[5]}, 32'h1);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      rd(8'h18, d);
      chk(d == 32'h0, "R12 unmapped 0x18 reads zero", d, 32'h0);
      rd(8'h00, d);
      chk(d == 32'h0, "R12 unmapped 0x00 reads zero", d, 32'h0);
      rd(A_STATUS, d);
      chk(d == 32'h20, "R12 status read", d, 32'h20);
      @(negedge clk);
      chk(reg_rdata == 32'h0, "R12 idle rdata zero", reg_rdata, 32'h0);
      clear_pin(5);
      chk(irq_req == 8'h00, "R7 all quiet", {24'h0, irq_req}, 32'h0);
   endtask

   initial begin
      t_reset();
      t_sense_rw();
      t_level();
      t_fall();
      t_rise();
      t_both();
      t_write_one();
      t_collide();
      t_unmapped();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule